// File: doc/BRIEF.md
# USB IN Endpoint Bank Controller

This block sits between a CPU register interface and the USB transmit engine of one device IN endpoint. It holds one or more packet banks, chosen by parameter. Software fills the bank it currently owns one byte at a time and then gives it to the USB side by writing the ownership-clear strobe. The USB side answers each host IN token in one of two ways. If a bank has been handed over, it streams that bank's bytes. If none has, it answers with a NAK pulse. The bank becomes free for software again only when the host acknowledges the packet.

Software sees three status flags. The transmit-ready flag can raise the endpoint interrupt. The ownership flag says the current bank belongs to software. The write-allowed flag says the current bank has room. A byte-count output gives the fill level of the current bank. Both sides walk the banks in round-robin order, each with its own pointer.

The outgoing byte stream uses valid/ready. Once valid is high, data, last and the empty-packet marker stay stable until ready is seen high at a clock edge. A beat transfers on every edge where valid and ready are both high. Holding ready low stalls the stream indefinitely and loses no byte.

Top module: `usb_in_ep_banks`

## Requirements
- R1: After reset all banks are free and empty, the CPU and USB pointers are at bank 0, transmit-ready, ownership and write-allowed are 1, the byte count is 0, and tx valid and NAK are 0.
- R2: The endpoint interrupt output equals the transmit-ready flag ANDed with the interrupt-enable input.
- R3: A one-cycle acknowledge strobe clears transmit-ready at the next edge and changes neither the byte count nor ownership.
- R4: A release strobe that arrives while transmit-ready is 1 is ignored: the bank stays with software and its byte count is unchanged.
- R5: A release strobe taken while transmit-ready is 0 and ownership is 1 hands the current bank to the USB side. If the next bank is not free, ownership, transmit-ready and write-allowed drop to 0, and CPU writes are dropped.
- R6: With several banks, an accepted release moves the CPU pointer to the next bank. Transmit-ready and ownership are reloaded from that bank's state: both become 1 at the same edge if it is free, and the byte count then shows that bank's level.
- R7: Write-allowed is 1 exactly while software owns the current bank and its count is below the bank size. A write taken then stores the byte and raises the count by one. A write to a full bank is dropped.
- R8: An IN token that arrives while the bank at the USB pointer has not been released produces a one-cycle NAK pulse on the cycle after the token, and no stream beat.
- R9: An IN token with a released bank streams its bytes in write order on valid/ready. Last is high only on the final byte. Outputs hold while ready is low.
- R10: A released bank holding zero bytes is sent as one beat with last = 1 and the empty-packet marker = 1.
- R11: A host-acknowledge pulse frees the sent bank, clears its count and advances the USB pointer. If that bank is the CPU's current bank, ownership and transmit-ready become 1 together. Without the pulse, the next token resends the same bank from its first byte.
- R12: The USB side sends released banks in the order software released them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_wr_en | input | 1 | Write one byte into the current bank |
| cpu_wr_data | input | 8 | Byte to write |
| cpu_ack_txrdy | input | 1 | Strobe: clear the transmit-ready flag |
| cpu_release | input | 1 | Strobe: clear ownership and hand the bank to USB |
| cpu_irq_en | input | 1 | Transmit-ready interrupt enable |
| txrdy_flag | output | 1 | Transmit-ready flag |
| own_flag | output | 1 | Software owns the current bank |
| wr_allowed | output | 1 | Current bank owned and not full |
| byte_count | output | CW | Fill level of the CPU's current bank |
| ep_irq | output | 1 | Endpoint interrupt |
| usb_in_token | input | 1 | Pulse: host IN token received |
| usb_nak | output | 1 | Pulse: answer NAK |
| usb_tx_valid | output | 1 | Stream byte valid |
| usb_tx_data | output | 8 | Stream byte |
| usb_tx_last | output | 1 | Final beat of the packet |
| usb_tx_zlp | output | 1 | Beat carries an empty packet |
| usb_tx_ready | input | 1 | Stream sink ready |
| usb_host_ack | input | 1 | Pulse: host acknowledged the packet |

## Verification
The assertions check the following on every cycle:
- The stream holds while stalled.
- A NAK follows only a token and never overlaps a beat.
- Transmit-ready never stands without ownership.
- An ignored release leaves the CPU pointer in place.
- A bank is never released twice or freed while still free.
- Counts never pass the bank size.

Only the bench scenarios can show the end-to-end sequences. These are the byte order of each packet, resending when no acknowledge comes, the reload of both flags when the banks rotate, the empty packet, and the round-robin order across both banks.

// File: rtl/inep_pkg.sv
package inep_pkg;
  typedef enum logic [0:0] {TX_IDLE = 1'b0, TX_SEND = 1'b1} tx_state_e;

  function automatic int ptr_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/inep_bank_state.sv
module inep_bank_state #(
  parameter int NUM_BANKS = 2,
  localparam int PW = inep_pkg::ptr_width(NUM_BANKS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 set_en,
  input  logic [PW-1:0]        set_idx,
  input  logic                 clr_en,
  input  logic [PW-1:0]        clr_idx,
  output logic [NUM_BANKS-1:0] rel_q,
  output logic [NUM_BANKS-1:0] rel_nxt
);
  always_comb begin
    rel_nxt = rel_q;
    if (set_en) rel_nxt[set_idx] = 1'b1;
    if (clr_en) rel_nxt[clr_idx] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rel_q <= '0;
    else        rel_q <= rel_nxt;
  end

  assert_no_double_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |-> !rel_q[set_idx]);
  assert_free_only_released_R11: assert property (@(posedge clk) disable iff (!rst_n)
    clr_en |-> rel_q[clr_idx]);
endmodule

// File: rtl/inep_bank_store.sv
module inep_bank_store #(
  parameter int NUM_BANKS  = 2,
  parameter int BANK_BYTES = 64,
  localparam int PW    = inep_pkg::ptr_width(NUM_BANKS),
  localparam int CW    = $clog2(BANK_BYTES + 1),
  localparam int IW    = (BANK_BYTES > 1) ? $clog2(BANK_BYTES) : 1,
  localparam int DEPTH = NUM_BANKS * BANK_BYTES,
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [PW-1:0] wr_bank,
  input  logic [7:0]    wr_data,
  input  logic          clr_en,
  input  logic [PW-1:0] clr_bank,
  input  logic [PW-1:0] rd_bank,
  input  logic [IW-1:0] rd_idx,
  output logic [7:0]    rd_data,
  output logic [CW-1:0] cnt_wr,
  output logic [CW-1:0] cnt_rd
);
  logic [7:0]    mem [DEPTH];
  logic [CW-1:0] cnt_q [NUM_BANKS];
  logic [AW-1:0] wr_addr, rd_addr;

  assign cnt_wr  = cnt_q[wr_bank];
  assign cnt_rd  = cnt_q[rd_bank];
  assign wr_addr = AW'(int'(wr_bank) * BANK_BYTES + int'(cnt_wr));
  assign rd_addr = AW'(int'(rd_bank) * BANK_BYTES + int'(rd_idx));
  assign rd_data = mem[rd_addr];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_cnt
    always_ff @(posedge clk) begin
      if (!rst_n)                                  cnt_q[b] <= '0;
      else if (clr_en && clr_bank == PW'(b))       cnt_q[b] <= '0;
      else if (wr_en && wr_bank == PW'(b))         cnt_q[b] <= cnt_q[b] + 1'b1;
    end

    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q[b] <= CW'(BANK_BYTES));
  end

  assert_write_fits_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> cnt_wr < CW'(BANK_BYTES));
endmodule

// File: rtl/inep_cpu_port.sv
module inep_cpu_port #(
  parameter int NUM_BANKS  = 2,
  parameter int BANK_BYTES = 64,
  localparam int PW = inep_pkg::ptr_width(NUM_BANKS),
  localparam int CW = $clog2(BANK_BYTES + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_req,
  input  logic                 rel_req,
  input  logic                 ack_req,
  input  logic                 irq_en,
  input  logic [NUM_BANKS-1:0] rel_q,
  input  logic [NUM_BANKS-1:0] rel_nxt,
  input  logic [CW-1:0]        cnt_cur,
  output logic [PW-1:0]        cpu_ptr,
  output logic                 wr_acc,
  output logic                 rel_acc,
  output logic                 txrdy,
  output logic                 own,
  output logic                 wr_allowed,
  output logic                 ep_irq
);
  logic [PW-1:0] ptr_nxt, ptr_inc;
  logic          own_nxt, newly_free, txrdy_d;

  assign own        = ~rel_q[cpu_ptr];
  assign wr_allowed = own && (cnt_cur < CW'(BANK_BYTES));
  assign wr_acc     = wr_req && wr_allowed;
  assign rel_acc    = rel_req && own && !txrdy;
  assign ep_irq     = txrdy && irq_en;

  assign ptr_inc    = (cpu_ptr == PW'(NUM_BANKS - 1)) ? '0 : cpu_ptr + 1'b1;
  assign ptr_nxt    = rel_acc ? ptr_inc : cpu_ptr;
  assign own_nxt    = ~rel_nxt[ptr_nxt];
  assign newly_free = own_nxt && (rel_acc || !own);

  always_comb begin
    txrdy_d = txrdy;
    if (ack_req)    txrdy_d = 1'b0;
    if (newly_free) txrdy_d = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cpu_ptr <= '0;
      txrdy   <= 1'b1;
    end else begin
      cpu_ptr <= ptr_nxt;
      txrdy   <= txrdy_d;
    end
  end

  assert_txrdy_needs_own_R6: assert property (@(posedge clk) disable iff (!rst_n)
    txrdy |-> own);
  assert_early_release_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rel_req && txrdy) |=> $stable(cpu_ptr));
  assert_ack_keeps_bank_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_req && own && !wr_req && !rel_req) |=> (own && $stable(cnt_cur) && $stable(cpu_ptr)));
endmodule

// File: rtl/inep_tx_engine.sv
module inep_tx_engine #(
  parameter int NUM_BANKS  = 2,
  parameter int BANK_BYTES = 64,
  localparam int PW = inep_pkg::ptr_width(NUM_BANKS),
  localparam int CW = $clog2(BANK_BYTES + 1),
  localparam int IW = (BANK_BYTES > 1) ? $clog2(BANK_BYTES) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_token,
  input  logic                 host_ack,
  input  logic                 tx_ready,
  input  logic [NUM_BANKS-1:0] rel_q,
  input  logic [CW-1:0]        cnt,
  input  logic [7:0]           rd_data,
  output logic [PW-1:0]        usb_ptr,
  output logic [IW-1:0]        rd_idx,
  output logic                 free_en,
  output logic                 nak,
  output logic                 tx_valid,
  output logic [7:0]           tx_data,
  output logic                 tx_last,
  output logic                 tx_zlp
);
  import inep_pkg::*;

  tx_state_e     state_q;
  logic [PW-1:0] ptr_inc;
  logic          empty;

  assign empty    = (cnt == '0);
  assign tx_valid = (state_q == TX_SEND);
  assign tx_zlp   = tx_valid && empty;
  assign tx_last  = tx_valid && (empty || CW'(rd_idx) == cnt - 1'b1);
  assign tx_data  = tx_zlp ? 8'h00 : rd_data;
  assign ptr_inc  = (usb_ptr == PW'(NUM_BANKS - 1)) ? '0 : usb_ptr + 1'b1;
  assign free_en  = (state_q == TX_IDLE) && !in_token && host_ack && rel_q[usb_ptr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= TX_IDLE;
      usb_ptr <= '0;
      rd_idx  <= '0;
      nak     <= 1'b0;
    end else begin
      nak <= 1'b0;
      unique case (state_q)
        TX_IDLE: begin
          if (in_token) begin
            if (rel_q[usb_ptr]) begin
              state_q <= TX_SEND;
              rd_idx  <= '0;
            end else begin
              nak <= 1'b1;
            end
          end else if (free_en) begin
            usb_ptr <= ptr_inc;
          end
        end
        TX_SEND: begin
          if (tx_ready) begin
            if (tx_last) state_q <= TX_IDLE;
            else         rd_idx  <= rd_idx + 1'b1;
          end
        end
        default: state_q <= TX_IDLE;
      endcase
    end
  end

  assert_stream_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last) && $stable(tx_zlp)));
  assert_nak_after_token_R8: assert property (@(posedge clk) disable iff (!rst_n)
    nak |-> ($past(in_token) && !tx_valid));
  assert_send_released_R12: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> rel_q[usb_ptr]);
endmodule

// File: rtl/usb_in_ep_banks.sv
module usb_in_ep_banks #(
  parameter int NUM_BANKS  = 2,
  parameter int BANK_BYTES = 64,
  localparam int PW = inep_pkg::ptr_width(NUM_BANKS),
  localparam int CW = $clog2(BANK_BYTES + 1),
  localparam int IW = (BANK_BYTES > 1) ? $clog2(BANK_BYTES) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_wr_en,
  input  logic [7:0]    cpu_wr_data,
  input  logic          cpu_ack_txrdy,
  input  logic          cpu_release,
  input  logic          cpu_irq_en,
  output logic          txrdy_flag,
  output logic          own_flag,
  output logic          wr_allowed,
  output logic [CW-1:0] byte_count,
  output logic          ep_irq,
  input  logic          usb_in_token,
  output logic          usb_nak,
  output logic          usb_tx_valid,
  output logic [7:0]    usb_tx_data,
  output logic          usb_tx_last,
  output logic          usb_tx_zlp,
  input  logic          usb_tx_ready,
  input  logic          usb_host_ack
);
  logic [NUM_BANKS-1:0] rel_q, rel_nxt;
  logic [PW-1:0]        cpu_ptr, usb_ptr;
  logic                 wr_acc, rel_acc, free_en;
  logic [IW-1:0]        rd_idx;
  logic [7:0]           rd_data;
  logic [CW-1:0]        cnt_cpu, cnt_usb;

  assign byte_count = cnt_cpu;

  inep_bank_state #(.NUM_BANKS(NUM_BANKS)) u_state (
    .clk(clk), .rst_n(rst_n),
    .set_en(rel_acc), .set_idx(cpu_ptr),
    .clr_en(free_en), .clr_idx(usb_ptr),
    .rel_q(rel_q), .rel_nxt(rel_nxt)
  );

  inep_bank_store #(.NUM_BANKS(NUM_BANKS), .BANK_BYTES(BANK_BYTES)) u_store (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_acc), .wr_bank(cpu_ptr), .wr_data(cpu_wr_data),
    .clr_en(free_en), .clr_bank(usb_ptr),
    .rd_bank(usb_ptr), .rd_idx(rd_idx), .rd_data(rd_data),
    .cnt_wr(cnt_cpu), .cnt_rd(cnt_usb)
  );

  inep_cpu_port #(.NUM_BANKS(NUM_BANKS), .BANK_BYTES(BANK_BYTES)) u_cpu (
    .clk(clk), .rst_n(rst_n),
    .wr_req(cpu_wr_en), .rel_req(cpu_release), .ack_req(cpu_ack_txrdy),
    .irq_en(cpu_irq_en), .rel_q(rel_q), .rel_nxt(rel_nxt), .cnt_cur(cnt_cpu),
    .cpu_ptr(cpu_ptr), .wr_acc(wr_acc), .rel_acc(rel_acc),
    .txrdy(txrdy_flag), .own(own_flag), .wr_allowed(wr_allowed), .ep_irq(ep_irq)
  );

  inep_tx_engine #(.NUM_BANKS(NUM_BANKS), .BANK_BYTES(BANK_BYTES)) u_tx (
    .clk(clk), .rst_n(rst_n),
    .in_token(usb_in_token), .host_ack(usb_host_ack), .tx_ready(usb_tx_ready),
    .rel_q(rel_q), .cnt(cnt_usb), .rd_data(rd_data),
    .usb_ptr(usb_ptr), .rd_idx(rd_idx), .free_en(free_en), .nak(usb_nak),
    .tx_valid(usb_tx_valid), .tx_data(usb_tx_data),
    .tx_last(usb_tx_last), .tx_zlp(usb_tx_zlp)
  );
endmodule

// File: tb/usb_in_ep_banks_test.sv
module usb_in_ep_banks_test;
  localparam int NB = 2;
  localparam int BB = 4;
  localparam int CW = $clog2(BB + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic cpu_wr_en = 0, cpu_ack_txrdy = 0, cpu_release = 0, cpu_irq_en = 0;
  logic [7:0] cpu_wr_data = '0;
  logic txrdy_flag, own_flag, wr_allowed, ep_irq;
  logic [CW-1:0] byte_count;
  logic usb_in_token = 0, usb_tx_ready = 0, usb_host_ack = 0;
  logic usb_nak, usb_tx_valid, usb_tx_last, usb_tx_zlp;
  logic [7:0] usb_tx_data;

  int n_cmp = 0, n_err = 0;
  bit finished = 0;
  logic [7:0] exp_q [BB];

  always #4 clk = ~clk;

  usb_in_ep_banks #(.NUM_BANKS(NB), .BANK_BYTES(BB)) uut (.*);

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr_byte(input logic [7:0] d);
    cpu_wr_en = 1; cpu_wr_data = d; step(); cpu_wr_en = 0;
  endtask

  task automatic strobe_ack();
    cpu_ack_txrdy = 1; step(); cpu_ack_txrdy = 0;
  endtask

  task automatic strobe_release();
    cpu_release = 1; step(); cpu_release = 0;
  endtask

  task automatic host_ack();
    usb_host_ack = 1; step(); usb_host_ack = 0;
  endtask

  task automatic recv_pkt(input int n, input string req, input bit bp);
    int got = 0;
    bit done = 0;
    usb_in_token = 1; step(); usb_in_token = 0;
    for (int c = 0; c < 40 && !done; c++) begin
      usb_tx_ready = bp ? c[0] : 1'b1;
      #1;
      if (usb_tx_valid && usb_tx_ready) begin
        if (n == 0) begin
          check({req, " empty marker"}, usb_tx_zlp, 1);
          check({req, " empty last"}, usb_tx_last, 1);
          done = 1;
        end else begin
          check({req, " data"}, usb_tx_data, exp_q[got]);
          check({req, " last"}, usb_tx_last, (got == n - 1));
          check({req, " marker"}, usb_tx_zlp, 0);
          if (usb_tx_last) done = 1;
        end
        got++;
      end
      step();
    end
    usb_tx_ready = 0;
    check({req, " beats"}, got, (n == 0) ? 1 : n);
    check({req, " idle after"}, usb_tx_valid, 0);
  endtask

  task automatic t_reset();
    check("R1 txrdy", txrdy_flag, 1);
    check("R1 own", own_flag, 1);
    check("R1 wr_allowed", wr_allowed, 1);
    check("R1 count", byte_count, 0);
    check("R1 valid", usb_tx_valid, 0);
    check("R1 nak", usb_nak, 0);
    check("R2 irq off", ep_irq, 0);
  endtask

  task automatic t_early_release_and_ack();
    wr_byte(8'hA0); wr_byte(8'hA1); wr_byte(8'hA2);
    check("R7 count 3", byte_count, 3);
    strobe_release();
    check("R4 count kept", byte_count, 3);
    check("R4 own kept", own_flag, 1);
    check("R4 txrdy kept", txrdy_flag, 1);
    strobe_ack();
    check("R3 txrdy cleared", txrdy_flag, 0);
    check("R3 own kept", own_flag, 1);
    check("R3 count kept", byte_count, 3);
    cpu_irq_en = 1; #1;
    check("R2 irq with txrdy 0", ep_irq, 0);
  endtask

  task automatic t_fill_full();
    wr_byte(8'hA3);
    check("R7 count full", byte_count, 4);
    check("R7 wr_allowed low", wr_allowed, 0);
    wr_byte(8'hAF);
    check("R7 dropped write", byte_count, 4);
  endtask

  task automatic t_rotate_free();
    strobe_release();
    check("R6 own reload", own_flag, 1);
    check("R6 txrdy reload", txrdy_flag, 1);
    check("R6 next count", byte_count, 0);
    check("R2 irq raised", ep_irq, 1);
    cpu_irq_en = 0; #1;
    check("R2 irq masked", ep_irq, 0);
  endtask

  task automatic t_rotate_busy();
    strobe_ack();
    wr_byte(8'hB0); wr_byte(8'hB1);
    strobe_release();
    check("R5 own cleared", own_flag, 0);
    check("R5 txrdy cleared", txrdy_flag, 0);
    check("R5 wr_allowed low", wr_allowed, 0);
    check("R5 shows bank0 count", byte_count, 4);
    wr_byte(8'hEE);
    check("R5 write dropped", byte_count, 4);
  endtask

  task automatic t_send_resend();
    for (int i = 0; i < BB; i++) exp_q[i] = 8'hA0 + 8'(i);
    recv_pkt(4, "R9 bank0 backpressure", 1);
    recv_pkt(4, "R11 resend without ack", 0);
    host_ack();
    check("R11 own back", own_flag, 1);
    check("R11 txrdy back", txrdy_flag, 1);
    check("R11 count cleared", byte_count, 0);
  endtask

  task automatic t_second_bank();
    exp_q[0] = 8'hB0; exp_q[1] = 8'hB1;
    recv_pkt(2, "R12 bank1 order", 0);
    host_ack();
    check("R12 own unchanged", own_flag, 1);
    check("R12 txrdy unchanged", txrdy_flag, 1);
  endtask

  task automatic t_nak();
    usb_in_token = 1; step(); usb_in_token = 0;
    check("R8 nak pulse", usb_nak, 1);
    check("R8 no beat", usb_tx_valid, 0);
    step();
    check("R8 nak one cycle", usb_nak, 0);
  endtask

  task automatic t_zero_length();
    strobe_ack();
    strobe_release();
    check("R10 rotate own", own_flag, 1);
    check("R10 rotate txrdy", txrdy_flag, 1);
    recv_pkt(0, "R10 empty packet", 0);
    host_ack();
    t_nak_after_zlp();
  endtask

  task automatic t_nak_after_zlp();
    usb_in_token = 1; step(); usb_in_token = 0;
    check("R11 freed then nak", usb_nak, 1);
    step();
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
  endtask

  initial begin
    repeat (3) step();
    rst_n = 1;
    step();
    t_reset();
    t_early_release_and_ack();
    t_fill_full();
    t_rotate_free();
    t_rotate_busy();
    t_send_resend();
    t_second_bank();
    t_nak();
    t_zero_length();
    finished = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_cmp++; n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end
endmodule